// File: doc/BRIEF.md
# Configurable Audio Serial Output Formatter

This block converts parallel left and right audio sample words into a single serial data line that is paced by an external bit clock and framed by an LR clock. Each channel occupies a 32-bit-clock slot: the left word is sent while the LR clock is high and the right word while it is low. A 3-bit format code selects the word length (16 or 20 bits), the bit order (MSB or LSB first) and whether the word sits at the start (front packed) or the end (rear packed) of its slot. Every slot position outside the active word carries 0.

A separate select bit replaces the audio data on the serial line with the per-sample validity flag of the channel being sent. The format code and the select bit live in a small control register that is written with a strobe. A mode-reset input clears both to 0 while it is low, so that on its release the block always starts in the default format: 16 bits, MSB first, rear packed, audio data.

The block runs on a fast system clock. The bit clock and the LR clock are brought in through synchronizers, and the serial output moves one position per detected falling edge of the bit clock. A 20-bit sample word is supplied per channel. The 16-bit formats send its upper 16 bits.

Top module: `audio_ser_fmt`

## Requirements
- R1: After the system reset `sdata` is 0, and without any configuration write the block behaves as format code 000 with the validity select cleared.
- R2: A slot starts at the first bit-clock falling edge on which the LR clock differs from its value at the previous falling edge. That edge carries slot position 0, and each later falling edge advances the position by one. LR high selects the left word and flag, LR low the right ones. `sdata` changes only after a bit-clock falling edge.
- R3: Code 000 sends 16 bits MSB first, rear packed: slot positions 16 to 31 carry sample bits 19 down to 4.
- R4: Code 001 sends 16 bits MSB first, front packed: slot positions 0 to 15 carry sample bits 19 down to 4.
- R5: Code 100 sends 20 bits MSB first on positions 12 to 31 (sample bit 19 first). Code 101 sends the same order on positions 0 to 19.
- R6: Code 110 sends 20 bits LSB first on positions 12 to 31 (sample bit 0 first). Code 111 sends the same order on positions 0 to 19.
- R7: Slot positions outside the active word, and any bit-clock falling edge after position 31 with no LR change, drive `sdata` to 0 while the validity select is clear.
- R8: Codes 010 and 011 behave exactly like code 000.
- R9: With the validity select set, `sdata` carries the current channel's validity flag at every position of the slot.
- R10: While `mode_rst_n` is low the format code and the validity select are held at 0, and a configuration write in the same cycle has no effect. After release they remain 0 until the next write.
- R11: The sample word and the validity flag are captured at the slot start. Changes on the sample inputs during a slot do not alter that slot's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than twice the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_rst_n | input | 1 | Synchronous active-low mode reset of the control register |
| cfg_we | input | 1 | Write strobe for the format code and the validity select |
| cfg_fmt | input | 3 | Format code: bit 2 wide word, bit 1 LSB first (wide only), bit 0 front packed |
| cfg_vsel | input | 1 | 1 routes the validity flag to `sdata` instead of audio data |
| bclk | input | 1 | Serial bit clock (asynchronous, sampled) |
| lrck | input | 1 | Channel framing clock: high = left, low = right |
| left_word | input | 20 | Left sample word |
| right_word | input | 20 | Right sample word |
| left_valid | input | 1 | Validity flag of the left sample |
| right_valid | input | 1 | Validity flag of the right sample |
| sdata | output | 1 | Serial audio data or validity flag |

## Verification
Two control actions can land in the same clock cycle: a mode reset and a configuration write. The bench provokes this by raising `cfg_we` with code 111 and the validity select set while `mode_rst_n` is low. It then releases the mode reset and judges the next full frame against the default 16-bit rear-packed audio pattern. Around that case every format code is swept with both select values and several sample patterns, and each slot position is compared against an arithmetic model of the packing.

// File: rtl/aof_pkg.sv
package aof_pkg;

  typedef struct packed {
    logic wide;       // 20-bit word instead of 16-bit
    logic lsb_first;  // bit order, only meaningful for the wide word
    logic front;      // word at the start of the slot
  } fmt_t;

  // Unlisted codes 010 and 011 fold to the default code 000.
  function automatic fmt_t decode_fmt(input logic [2:0] code);
    fmt_t f;
    f = '0;
    case (code)
      3'b001: f.front = 1'b1;
      3'b100: f.wide  = 1'b1;
      3'b101: begin f.wide = 1'b1; f.front = 1'b1; end
      3'b110: begin f.wide = 1'b1; f.lsb_first = 1'b1; end
      3'b111: begin f.wide = 1'b1; f.lsb_first = 1'b1; f.front = 1'b1; end
      default: f = '0;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/aof_ctrl.sv
module aof_ctrl
  import aof_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_rst_n,
  input  logic       cfg_we,
  input  logic [2:0] cfg_fmt,
  input  logic       cfg_vsel,
  output fmt_t       fmt,
  output logic       vsel
);

  logic [2:0] code_q, code_d;
  logic       vsel_q, vsel_d;

  always_comb begin
    code_d = code_q;
    vsel_d = vsel_q;
    if (!mode_rst_n) begin
      code_d = 3'b000;
      vsel_d = 1'b0;
    end else if (cfg_we) begin
      code_d = cfg_fmt;
      vsel_d = cfg_vsel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= 3'b000;
      vsel_q <= 1'b0;
    end else begin
      code_q <= code_d;
      vsel_q <= vsel_d;
    end
  end

  assign fmt  = decode_fmt(code_q);
  assign vsel = vsel_q;

  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_rst_n |=> (code_q == 3'b000 && !vsel_q)); // R10

endmodule

// File: rtl/aof_sync.sv
module aof_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic lrck,
  output logic bclk_fall,
  output logic lrck_s
);

  // bclk keeps one extra stage to compare against for edge detection
  logic [SYNC_STAGES:0]   bclk_q, bclk_d;
  logic [SYNC_STAGES-1:0] lr_q, lr_d;

  always_comb begin
    for (int i = 0; i <= SYNC_STAGES; i++) begin
      bclk_d[i] = (i == 0) ? bclk : bclk_q[i-1];
    end
    for (int i = 0; i < SYNC_STAGES; i++) begin
      lr_d[i] = (i == 0) ? lrck : lr_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= '0;
      lr_q   <= '0;
    end else begin
      bclk_q <= bclk_d;
      lr_q   <= lr_d;
    end
  end

  assign bclk_fall = bclk_q[SYNC_STAGES] & ~bclk_q[SYNC_STAGES-1];
  assign lrck_s    = lr_q[SYNC_STAGES-1];

endmodule

// File: rtl/aof_slot.sv
module aof_slot #(
  parameter int SAMPLE_W  = 20,
  parameter int SLOT_BITS = 32,
  parameter int POS_W     = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_fall,
  input  logic                lrck_s,
  input  logic [SAMPLE_W-1:0] left_word,
  input  logic [SAMPLE_W-1:0] right_word,
  input  logic                left_valid,
  input  logic                right_valid,
  output logic [POS_W-1:0]    pos,
  output logic [SAMPLE_W-1:0] word,
  output logic                vflag,
  output logic                slot_idle
);

  localparam logic [POS_W-1:0] POS_IDLE = POS_W'(SLOT_BITS);

  logic                lr_prev_q, lr_prev_d;
  logic [POS_W-1:0]    pos_q, pos_d;
  logic [SAMPLE_W-1:0] word_q, word_d;
  logic                vflag_q, vflag_d;
  logic                start;

  assign start = bclk_fall & (lrck_s != lr_prev_q);

  always_comb begin
    lr_prev_d = lr_prev_q;
    pos_d     = pos_q;
    word_d    = word_q;
    vflag_d   = vflag_q;
    if (bclk_fall) begin
      lr_prev_d = lrck_s;
      if (start) begin
        pos_d   = '0;
        word_d  = lrck_s ? left_word  : right_word;
        vflag_d = lrck_s ? left_valid : right_valid;
      end else if (pos_q != POS_IDLE) begin
        pos_d = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_prev_q <= 1'b0;
      pos_q     <= POS_IDLE;
      word_q    <= '0;
      vflag_q   <= 1'b0;
    end else begin
      lr_prev_q <= lr_prev_d;
      pos_q     <= pos_d;
      word_q    <= word_d;
      vflag_q   <= vflag_d;
    end
  end

  assign pos       = pos_q;
  assign word      = word_q;
  assign vflag     = vflag_q;
  assign slot_idle = (pos_q == POS_IDLE);

  AST_SLOT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (pos_q == '0)); // R2

  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(word_q) && $stable(vflag_q))); // R11

  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= POS_IDLE); // R7

endmodule

// File: rtl/aof_pick.sv
module aof_pick
  import aof_pkg::*;
#(
  parameter int SAMPLE_W  = 20,
  parameter int NARROW_W  = 16,
  parameter int SLOT_BITS = 32,
  parameter int POS_W     = 6
) (
  input  fmt_t                fmt,
  input  logic                vsel,
  input  logic [POS_W-1:0]    pos,
  input  logic [SAMPLE_W-1:0] word,
  input  logic                vflag,
  output logic                bit_o
);

  localparam int IDX_W = $clog2(SAMPLE_W);

  logic [POS_W-1:0] len;
  logic [POS_W-1:0] first;
  logic [POS_W-1:0] k;
  logic             active;
  logic [IDX_W-1:0] idx;

  always_comb begin
    len    = fmt.wide  ? POS_W'(SAMPLE_W) : POS_W'(NARROW_W);
    first  = fmt.front ? '0 : (POS_W'(SLOT_BITS) - len);
    k      = pos - first;
    active = (pos >= first) && (k < len);
    // MSB-first counts down from the top sample bit; narrow word uses the upper bits
    idx    = fmt.lsb_first ? k[IDX_W-1:0]
                           : (IDX_W'(SAMPLE_W - 1) - k[IDX_W-1:0]);
    bit_o  = vsel ? vflag : (active & word[idx]);
  end

endmodule

// File: rtl/audio_ser_fmt.sv
module audio_ser_fmt
  import aof_pkg::*;
#(
  parameter int SAMPLE_W    = 20,
  parameter int NARROW_W    = 16,
  parameter int SLOT_BITS   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_rst_n,
  input  logic                cfg_we,
  input  logic [2:0]          cfg_fmt,
  input  logic                cfg_vsel,
  input  logic                bclk,
  input  logic                lrck,
  input  logic [SAMPLE_W-1:0] left_word,
  input  logic [SAMPLE_W-1:0] right_word,
  input  logic                left_valid,
  input  logic                right_valid,
  output logic                sdata
);

  localparam int POS_W = $clog2(SLOT_BITS + 1);

  logic [1:0]          rst_pipe;
  logic                rst_sync_n;
  fmt_t                fmt;
  logic                vsel;
  logic                bclk_fall;
  logic                lrck_s;
  logic [POS_W-1:0]    pos;
  logic [SAMPLE_W-1:0] word;
  logic                vflag;
  logic                slot_idle;
  logic                pick_bit;
  logic                fall_d_q;
  logic                sdata_q, sdata_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  aof_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .mode_rst_n (mode_rst_n),
    .cfg_we     (cfg_we),
    .cfg_fmt    (cfg_fmt),
    .cfg_vsel   (cfg_vsel),
    .fmt        (fmt),
    .vsel       (vsel)
  );

  aof_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bclk      (bclk),
    .lrck      (lrck),
    .bclk_fall (bclk_fall),
    .lrck_s    (lrck_s)
  );

  aof_slot #(.SAMPLE_W(SAMPLE_W), .SLOT_BITS(SLOT_BITS), .POS_W(POS_W)) u_slot (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .bclk_fall   (bclk_fall),
    .lrck_s      (lrck_s),
    .left_word   (left_word),
    .right_word  (right_word),
    .left_valid  (left_valid),
    .right_valid (right_valid),
    .pos         (pos),
    .word        (word),
    .vflag       (vflag),
    .slot_idle   (slot_idle)
  );

  aof_pick #(.SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W),
             .SLOT_BITS(SLOT_BITS), .POS_W(POS_W)) u_pick (
    .fmt   (fmt),
    .vsel  (vsel),
    .pos   (pos),
    .word  (word),
    .vflag (vflag),
    .bit_o (pick_bit)
  );

  // output updates one cycle after the slot state so it sees the new position and word
  always_comb begin
    sdata_d = fall_d_q ? pick_bit : sdata_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      fall_d_q <= 1'b0;
      sdata_q  <= 1'b0;
    end else begin
      fall_d_q <= bclk_fall;
      sdata_q  <= sdata_d;
    end
  end

  assign sdata = sdata_q;

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !fall_d_q |=> $stable(sdata_q)); // R2

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fall_d_q && slot_idle && !vsel) |=> !sdata_q); // R7

  AST_VALID_ROUTE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fall_d_q && vsel) |=> (sdata_q == $past(vflag))); // R9

endmodule

// File: tb/sim_audio_ser_fmt.sv
`timescale 1ns/1ps
module sim_audio_ser_fmt;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_fmt;
  logic        cfg_vsel;
  logic        bclk;
  logic        lrck;
  logic [19:0] left_word;
  logic [19:0] right_word;
  logic        left_valid;
  logic        right_valid;
  logic        sdata;

  int n_cmp  = 0;
  int n_miss = 0;

  always #2 clk = ~clk; // 250 MHz

  audio_ser_fmt u0 (
    .clk(clk), .rst_n(rst_n), .mode_rst_n(mode_rst_n), .cfg_we(cfg_we),
    .cfg_fmt(cfg_fmt), .cfg_vsel(cfg_vsel), .bclk(bclk), .lrck(lrck),
    .left_word(left_word), .right_word(right_word),
    .left_valid(left_valid), .right_valid(right_valid), .sdata(sdata)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_miss++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  // arithmetic model of the slot packing
  function automatic logic exp_bit(input logic [2:0] code, input logic vs,
                                   input logic [19:0] w, input logic v, input int p);
    int len, first, k;
    logic lsb;
    if (vs) return v;
    case (code)
      3'b001:  begin len = 16; first = 0;  lsb = 1'b0; end
      3'b100:  begin len = 20; first = 12; lsb = 1'b0; end
      3'b101:  begin len = 20; first = 0;  lsb = 1'b0; end
      3'b110:  begin len = 20; first = 12; lsb = 1'b1; end
      3'b111:  begin len = 20; first = 0;  lsb = 1'b1; end
      default: begin len = 16; first = 16; lsb = 1'b0; end
    endcase
    if (p < first || p >= first + len) return 1'b0;
    k = p - first;
    return lsb ? w[k] : w[19 - k];
  endfunction

  function automatic string tag_of(input logic [2:0] code, input logic vs, input int p);
    if (vs) return "R9";
    if (code == 3'b010 || code == 3'b011) return "R8";
    if (exp_bit(code, 1'b0, 20'hFFFFF, 1'b0, p) == 1'b0) return "R7";
    case (code)
      3'b000:  return "R3";
      3'b001:  return "R4";
      3'b100, 3'b101: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input logic got, input logic exp, input string ctx);
    n_cmp++;
    if (got !== exp) begin
      n_miss++;
      $display("FAIL %s %s: got %0b expected %0b", tag, ctx, got, exp);
    end
  endtask

  task automatic write_cfg(input logic [2:0] code, input logic vs);
    @(negedge clk);
    cfg_we = 1'b1; cfg_fmt = code; cfg_vsel = vs;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one frame: left slot (lrck high) then right slot (lrck low); R2 slot framing
  task automatic run_frame(input logic [19:0] l, input logic [19:0] r,
                           input logic vl, input logic vr,
                           input logic [2:0] code, input logic vs,
                           input string tag_ovr, input bit disturb);
    left_word = l; right_word = r; left_valid = vl; right_valid = vr;
    for (int ch = 0; ch < 2; ch++) begin
      for (int p = 0; p < 32; p++) begin
        @(negedge clk);
        bclk = 1'b0;
        if (p == 0) lrck = (ch == 0);
        repeat (8) @(negedge clk);
        check((tag_ovr != "") ? tag_ovr : tag_of(code, vs, p), sdata,
              exp_bit(code, vs, (ch == 0) ? l : r, (ch == 0) ? vl : vr, p),
              $sformatf("R2 code=%03b vsel=%0b %s pos=%0d", code, vs,
                        (ch == 0) ? "left" : "right", p));
        if (disturb && p == 5) begin
          if (ch == 0) begin left_word = ~l; left_valid = ~vl; end
          else         begin right_word = ~r; right_valid = ~vr; end
        end
        if (p == 31) begin
          left_word = l; right_word = r; left_valid = vl; right_valid = vr;
        end
        bclk = 1'b1;
        repeat (8) @(negedge clk);
      end
    end
  endtask

  logic [19:0] pat_l [3];
  logic [19:0] pat_r [3];

  initial begin
    pat_l[0] = 20'hA5C3F; pat_r[0] = 20'h80001;
    pat_l[1] = 20'h12345; pat_r[1] = 20'h7FFFE;
    pat_l[2] = 20'hFFFFF; pat_r[2] = 20'h0F0F0;

    rst_n = 1'b0; mode_rst_n = 1'b1; cfg_we = 1'b0; cfg_fmt = 3'b000; cfg_vsel = 1'b0;
    bclk = 1'b1; lrck = 1'b0;
    left_word = '0; right_word = '0; left_valid = 1'b0; right_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1", sdata, 1'b0, "reset state");

    // R7: bit clock running with no LR change keeps the line low
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); bclk = 1'b0;
      repeat (8) @(negedge clk);
      check("R7", sdata, 1'b0, "idle before first slot");
      bclk = 1'b1;
      repeat (8) @(negedge clk);
    end

    // R1: default format without any write
    run_frame(20'hC3A5F, 20'h5A5A5, 1'b1, 1'b0, 3'b000, 1'b0, "R1", 1'b0);

    // sweep: every code, both select values, several sample patterns (R3..R9)
    for (int c = 0; c < 8; c++) begin
      for (int v = 0; v < 2; v++) begin
        write_cfg(3'(c), 1'(v));
        for (int s = 0; s < 3; s++) begin
          run_frame(pat_l[s], pat_r[s], 1'(s), 1'(s + 1), 3'(c), 1'(v), "", 1'b0);
        end
      end
    end

    // R11: inputs change mid-slot, output follows captured values
    write_cfg(3'b100, 1'b0);
    run_frame(20'h9C3E1, 20'h36A5B, 1'b1, 1'b0, 3'b100, 1'b0, "R11", 1'b1);
    write_cfg(3'b110, 1'b1);
    run_frame(20'h9C3E1, 20'h36A5B, 1'b0, 1'b1, 3'b110, 1'b1, "R11", 1'b1);

    // R10: mode reset and config write in the same cycle; reset wins
    write_cfg(3'b111, 1'b1);
    @(negedge clk);
    mode_rst_n = 1'b0; cfg_we = 1'b1; cfg_fmt = 3'b111; cfg_vsel = 1'b1;
    @(negedge clk);
    mode_rst_n = 1'b1; cfg_we = 1'b0;
    run_frame(20'hB7E15, 20'h4D2C9, 1'b1, 1'b1, 3'b000, 1'b0, "R10", 1'b0);

    summary();
    $finish;
  end

endmodule